// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Unit

This unit collects the event pulses produced by an SD host controller's command, data and DMA engines into a sticky raw status register. It qualifies that register with a per-bit mask and a global enable bit, and drives a single registered, level-sensitive interrupt line. Beside the raw status it holds a card-presence flag that follows a card-detect level, and a separate DMA status register whose software clear reaches only its low field. The global control word lives here too. Its three reset-request bits never read back as ones and are handed out as one-cycle pulses.

Software reaches every register through a small 32-bit word-addressed port. The port has a write strobe and a read strobe, and read data is registered. Event sources are outside the block and only deliver single-cycle pulses or levels.

Top module: `sdh_irq_unit`

## Requirements
- R1: After reset, control reads 0x00000300, and mask, raw status and DMA status read 0. The card status word (address 4) has bit 8 set, and the interrupt line, the DMA enable and the reset requests are low.
- R2: A one-cycle pulse on event input bit n (n below 30) sets raw status bit n (address 3), and the bit stays set until software clears it.
- R3: A write to the raw status address (3) or to the masked status address (2) clears each raw bit whose written bit is 1. Bits written as 0 are left unchanged.
- R4: The masked status address (2) reads the raw status ANDed with the mask register (address 1).
- R5: The interrupt line is high only when control bit 4 is set and the raw status ANDed with the mask is nonzero. It follows any change in status, mask or enable exactly one clock later.
- R6: When an event pulse and a clearing write hit the same raw bit in the same cycle, the bit ends up set.
- R7: A rising card-detect level sets raw bit 30, clears raw bit 31 and sets card status bit 8. A falling level sets raw bit 31, clears raw bit 30 and clears bit 8. Writing 1 to bit 8 of address 4 clears that bit.
- R8: Control (address 0) bits 2:0 always read 0. A write drives those bits onto the reset request outputs for exactly one cycle. Control bit 5 drives the DMA enable output.
- R9: DMA status (address 5) bit 0 is set by transmit-done and bit 1 by receive-done, and either one also sets bit 8. A write clears a bit only if it is written as 1 and lies in bits 9:0. Bits 10 and above are only set by the DMA flag inputs and never cleared by writes.
- R10: Card status bit 17 reads the FIFO-ready level and bit 2 reads its inverse at the moment of the read. Neither is stored.
- R11: Read data appears on the clock edge that samples the read strobe and holds while the strobe is low. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Word address of the register port |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| evt_i | input | DATA_W-2 | Event pulses into raw status bits below 30 |
| dma_tx_done_i | input | 1 | DMA transmit-done pulse |
| dma_rx_done_i | input | 1 | DMA receive-done pulse |
| dma_evt_i | input | DATA_W | Direct set pulses into DMA status |
| card_i | input | 1 | Card-detect level, already in the clock domain |
| fifo_ready_i | input | 1 | FIFO-has-data level |
| irq_o | output | 1 | Registered interrupt line |
| dma_en_o | output | 1 | DMA enable from control bit 5 |
| rst_req_o | output | 3 | One-cycle soft, FIFO and DMA reset requests |

## Verification
A hardware event pulse and a software clearing write can land on the same raw status bit in one cycle. The bench provokes this by asserting an event bit and a write-1-to-clear covering that bit and a second, already set bit on the same clock edge. It then reads raw status and expects the event bit to survive while the other bit is gone. The same kind of collision between a card-detect edge and a write to the card status bit is decided in favour of the edge. Around these cases, single-bit sweeps over every event bit and every clearable DMA bit compare read values against masks computed in the bench.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int ISU_DW    = 32;
  localparam int ISU_AW    = 3;
  localparam int ISU_NRST  = 3;

  localparam logic [ISU_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [ISU_AW-1:0] A_MASK  = 3'd1;
  localparam logic [ISU_AW-1:0] A_MSTAT = 3'd2;
  localparam logic [ISU_AW-1:0] A_RSTAT = 3'd3;
  localparam logic [ISU_AW-1:0] A_CSTAT = 3'd4;
  localparam logic [ISU_AW-1:0] A_DSTAT = 3'd5;

  localparam int B_IRQ_EN  = 4;
  localparam int B_DMA_EN  = 5;
  localparam int B_PRESENT = 8;
  localparam int B_FLEVEL  = 17;
  localparam int B_FEMPTY  = 2;
  localparam int D_TX      = 0;
  localparam int D_RX      = 1;
  localparam int D_SUM     = 8;

  localparam logic [ISU_DW-1:0] CTRL_RESET = 32'h0000_0300;
endpackage

// File: rtl/isu_w1c_bank.sv
module isu_w1c_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] CLR_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] wclr_i,
  input  logic [W-1:0] hclr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] nxt;

  // per-bit next state: set has priority over both clear sources
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign nxt[i] = set_i[i] ? 1'b1 :
                    (((wclr_i[i] && CLR_MASK[i]) || hclr_i[i]) ? 1'b0 : q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign q_o = q;

  // R6: a pulsed bit is set on the next cycle whatever else happened
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R3: a software clear of a clearable, unpulsed bit takes effect
  p_w1c_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (|(wclr_i & CLR_MASK & ~set_i)) |=> ((q_o & $past(wclr_i & CLR_MASK & ~set_i)) == '0));

  // R9: bits outside the clearable field never drop through a write
  p_upper_keep_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(q_o) & ~CLR_MASK & ~$past(hclr_i)) & ~q_o) == '0));
endmodule

// File: rtl/isu_ctrl_reg.sv
module isu_ctrl_reg #(
  parameter int W = 32,
  parameter int NRST = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    ctrl_o,
  output logic [NRST-1:0] rstreq_o
);
  logic [W-1:0]    ctrl_q;
  logic [NRST-1:0] req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= RST_VAL & ~W'((1 << NRST) - 1);
      req_q  <= '0;
    end else begin
      req_q <= we_i ? wdata_i[NRST-1:0] : '0;
      if (we_i) ctrl_q <= {wdata_i[W-1:NRST], {NRST{1'b0}}};
    end
  end

  assign ctrl_o   = ctrl_q;
  assign rstreq_o = req_q;

  // R8: a reset request only follows a control write
  p_req_after_write_r8: assert property (@(posedge clk) disable iff (rst)
    (|rstreq_o) |-> $past(we_i));

  // R8: a request lasts a single cycle unless a new write arrives
  p_req_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    ((|rstreq_o) && !we_i) |=> (rstreq_o == '0));
endmodule

// File: rtl/isu_card_detect.sv
module isu_card_detect (
  input  logic clk,
  input  logic rst,
  input  logic card_i,
  input  logic clr_i,
  output logic ins_o,
  output logic rem_o,
  output logic present_o
);
  logic prev_q;
  logic pres_q;

  assign ins_o = card_i && !prev_q;
  assign rem_o = !card_i && prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pres_q <= 1'b1;
    end else begin
      prev_q <= card_i;
      if (ins_o)      pres_q <= 1'b1;
      else if (rem_o) pres_q <= 1'b0;
      else if (clr_i) pres_q <= 1'b0;
    end
  end

  assign present_o = pres_q;

  // R7: an insertion edge leaves the present flag set
  p_insert_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(card_i) |=> present_o);

  // R7: a removal edge leaves the present flag clear
  p_remove_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(card_i) |=> !present_o);
endmodule

// File: rtl/isu_irq_out.sv
module isu_irq_out #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] masked_o,
  output logic         irq_o
);
  logic irq_q;

  assign masked_o = raw_i & mask_i;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= en_i && (|masked_o);
  end

  assign irq_o = irq_q;

  // R5: the line needs the global enable one cycle earlier
  p_irq_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(en_i));

  // R5: the line needs a pending unmasked bit one cycle earlier
  p_irq_needs_src_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(raw_i & mask_i)));

  // R5: an enabled pending bit raises the line on the next cycle
  p_irq_raise_r5: assert property (@(posedge clk) disable iff (rst)
    (en_i && (|(raw_i & mask_i))) |=> irq_o);
endmodule

// File: rtl/sdh_irq_unit.sv
module sdh_irq_unit
  import isu_pkg::*;
#(
  parameter int DATA_W    = ISU_DW,
  parameter int ADDR_W    = ISU_AW,
  parameter int DMA_CLR_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic                reg_re,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [DATA_W-3:0]   evt_i,
  input  logic                dma_tx_done_i,
  input  logic                dma_rx_done_i,
  input  logic [DATA_W-1:0]   dma_evt_i,
  input  logic                card_i,
  input  logic                fifo_ready_i,
  output logic                irq_o,
  output logic                dma_en_o,
  output logic [ISU_NRST-1:0] rst_req_o
);
  localparam int INS_B = DATA_W - 2;
  localparam int REM_B = DATA_W - 1;
  localparam logic [DATA_W-1:0] DMA_MASK =
    {{(DATA_W-DMA_CLR_W){1'b0}}, {DMA_CLR_W{1'b1}}};
  localparam logic [DATA_W-1:0] RAW_MASK = {DATA_W{1'b1}};

  // address decode
  logic we_ctrl, we_mask, we_raw, we_cstat, we_dstat;
  assign we_ctrl  = reg_we && (reg_addr == ADDR_W'(A_CTRL));
  assign we_mask  = reg_we && (reg_addr == ADDR_W'(A_MASK));
  assign we_raw   = reg_we && ((reg_addr == ADDR_W'(A_RSTAT)) ||
                               (reg_addr == ADDR_W'(A_MSTAT)));
  assign we_cstat = reg_we && (reg_addr == ADDR_W'(A_CSTAT));
  assign we_dstat = reg_we && (reg_addr == ADDR_W'(A_DSTAT));

  // control word
  logic [DATA_W-1:0] ctrl;
  isu_ctrl_reg #(.W(DATA_W), .NRST(ISU_NRST), .RST_VAL(DATA_W'(CTRL_RESET))) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .we_i     (we_ctrl),
    .wdata_i  (reg_wdata),
    .ctrl_o   (ctrl),
    .rstreq_o (rst_req_o)
  );
  assign dma_en_o = ctrl[B_DMA_EN];

  // mask register
  logic [DATA_W-1:0] mask_q;
  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (we_mask) mask_q <= reg_wdata;
  end

  // card detect
  logic ins_ev, rem_ev, present;
  isu_card_detect u_card (
    .clk       (clk),
    .rst       (rst),
    .card_i    (card_i),
    .clr_i     (we_cstat && reg_wdata[B_PRESENT]),
    .ins_o     (ins_ev),
    .rem_o     (rem_ev),
    .present_o (present)
  );

  // raw status
  logic [DATA_W-1:0] raw_set, raw_wclr, raw_hclr, raw_q;
  assign raw_set  = {rem_ev, ins_ev, evt_i};
  assign raw_wclr = we_raw ? reg_wdata : '0;
  assign raw_hclr = {ins_ev, rem_ev, {(DATA_W-2){1'b0}}};

  isu_w1c_bank #(.W(DATA_W), .CLR_MASK(RAW_MASK)) u_raw (
    .clk    (clk),
    .rst    (rst),
    .set_i  (raw_set),
    .wclr_i (raw_wclr),
    .hclr_i (raw_hclr),
    .q_o    (raw_q)
  );

  // DMA status
  logic [DATA_W-1:0] dma_set, dma_wclr, dma_q;
  always_comb begin
    dma_set        = dma_evt_i;
    dma_set[D_TX]  = dma_evt_i[D_TX]  | dma_tx_done_i;
    dma_set[D_RX]  = dma_evt_i[D_RX]  | dma_rx_done_i;
    dma_set[D_SUM] = dma_evt_i[D_SUM] | dma_tx_done_i | dma_rx_done_i;
  end
  assign dma_wclr = we_dstat ? reg_wdata : '0;

  isu_w1c_bank #(.W(DATA_W), .CLR_MASK(DMA_MASK)) u_dma (
    .clk    (clk),
    .rst    (rst),
    .set_i  (dma_set),
    .wclr_i (dma_wclr),
    .hclr_i ({DATA_W{1'b0}}),
    .q_o    (dma_q)
  );

  // interrupt output
  logic [DATA_W-1:0] masked;
  isu_irq_out #(.W(DATA_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .en_i     (ctrl[B_IRQ_EN]),
    .raw_i    (raw_q),
    .mask_i   (mask_q),
    .masked_o (masked),
    .irq_o    (irq_o)
  );

  // read path
  logic [DATA_W-1:0] cstat, rd_mux, rdata_q;
  always_comb begin
    cstat            = '0;
    cstat[B_PRESENT] = present;
    cstat[B_FLEVEL]  = fifo_ready_i;
    cstat[B_FEMPTY]  = !fifo_ready_i;
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(A_CTRL))  rd_mux = ctrl;
    if (reg_addr == ADDR_W'(A_MASK))  rd_mux = mask_q;
    if (reg_addr == ADDR_W'(A_MSTAT)) rd_mux = masked;
    if (reg_addr == ADDR_W'(A_RSTAT)) rd_mux = raw_q;
    if (reg_addr == ADDR_W'(A_CSTAT)) rd_mux = cstat;
    if (reg_addr == ADDR_W'(A_DSTAT)) rd_mux = dma_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_re) rdata_q <= rd_mux;
  end
  assign reg_rdata = rdata_q;

  // R7: insert and remove flags can never be pending together
  p_card_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(raw_q[INS_B] && raw_q[REM_B]));

  // R11: read data holds while no read is strobed
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !reg_re |=> $stable(reg_rdata));
endmodule

// File: tb/tb_sdh_irq_unit.sv
module tb_sdh_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic          reg_re = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [DW-3:0] evt_i = '0;
  logic          dma_tx_done_i = 1'b0;
  logic          dma_rx_done_i = 1'b0;
  logic [DW-1:0] dma_evt_i = '0;
  logic          card_i = 1'b1;
  logic          fifo_ready_i = 1'b0;
  logic          irq_o;
  logic          dma_en_o;
  logic [2:0]    rst_req_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  sdh_irq_unit dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
    .dma_tx_done_i(dma_tx_done_i), .dma_rx_done_i(dma_rx_done_i),
    .dma_evt_i(dma_evt_i), .card_i(card_i), .fifo_ready_i(fifo_ready_i),
    .irq_o(irq_o), .dma_en_o(dma_en_o), .rst_req_o(rst_req_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp=<%0d cycles", cycles, WATCHDOG);
      report();
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [DW-3:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  logic [DW-1:0] v;
  logic [DW-1:0] m;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    rd(3'd0, v); chk("R1 ctrl", v, 32'h300);
    rd(3'd1, v); chk("R1 mask", v, 0);
    rd(3'd3, v); chk("R1 raw", v, 0);
    rd(3'd5, v); chk("R1 dma", v, 0);
    rd(3'd4, v); chk("R1/R10 cstat", v, 32'h104);
    chk("R1 irq/dma_en/req", {28'd0, irq_o, dma_en_o, rst_req_o}, 0);

    // R10: fifo level reflected at read time
    fifo_ready_i = 1'b1;
    rd(3'd4, v); chk("R10 cstat ready", v, 32'h20100);

    // R2/R3/R4 sweep over every event bit
    for (int b = 0; b < 30; b++) begin
      pulse(30'(1) << b);
      rd(3'd3, v); chk("R2 raw bit", v, 32'(1) << b);
      m = (b % 2 == 1) ? 32'hAAAA_AAAA : 32'h5555_5555;
      wr(3'd1, m);
      rd(3'd2, v); chk("R4 masked", v, (32'(1) << b) & m);
      chk("R5 irq disabled", {31'd0, irq_o}, 0);
      wr((b % 2 == 1) ? 3'd2 : 3'd3, 32'(1) << b);
      rd(3'd3, v); chk("R3 cleared", v, 0);
    end

    // R3: partial clear leaves unwritten bits
    pulse(30'h28);
    wr(3'd3, 32'h8);
    rd(3'd3, v); chk("R3 partial", v, 32'h20);

    // R5: interrupt timing
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, 32'h310);
    pulse(30'h8);
    chk("R5 irq not yet", {31'd0, irq_o}, 0);
    @(negedge clk);
    chk("R5 irq high", {31'd0, irq_o}, 1);
    wr(3'd1, 32'h0);
    chk("R5 irq lag mask", {31'd0, irq_o}, 1);
    @(negedge clk);
    chk("R5 irq masked off", {31'd0, irq_o}, 0);
    wr(3'd1, 32'h8);
    @(negedge clk);
    chk("R5 irq unmasked", {31'd0, irq_o}, 1);
    wr(3'd0, 32'h300);
    @(negedge clk);
    chk("R5 irq enable off", {31'd0, irq_o}, 0);

    // R6: event and clear on the same bit in the same cycle
    wr(3'd3, 32'hFFFF_FFFF);
    pulse(30'h20);
    @(negedge clk);
    evt_i = 30'h80; reg_addr = 3'd3; reg_wdata = 32'hA0; reg_we = 1'b1;
    @(negedge clk);
    evt_i = '0; reg_we = 1'b0;
    rd(3'd3, v); chk("R6 set wins", v, 32'h80);

    // R7: card remove / insert
    wr(3'd3, 32'hFFFF_FFFF);
    @(negedge clk); card_i = 1'b0;
    rd(3'd3, v); chk("R7 remove raw", v, 32'h8000_0000);
    rd(3'd4, v); chk("R7 remove cstat", v, 32'h20000);
    @(negedge clk); card_i = 1'b1;
    rd(3'd3, v); chk("R7 insert raw", v, 32'h4000_0000);
    rd(3'd4, v); chk("R7 insert cstat", v, 32'h20100);
    wr(3'd4, 32'h100);
    rd(3'd4, v); chk("R7 present w1c", v, 32'h20000);
    wr(3'd3, 32'hFFFF_FFFF);

    // R8: control self-clearing bits and DMA enable
    wr(3'd0, 32'h327);
    chk("R8 req pulse", {29'd0, rst_req_o}, 7);
    chk("R8 dma_en", {31'd0, dma_en_o}, 1);
    @(negedge clk);
    chk("R8 req gone", {29'd0, rst_req_o}, 0);
    rd(3'd0, v); chk("R8 ctrl readback", v, 32'h320);
    wr(3'd0, 32'h302);
    chk("R8 req fifo only", {29'd0, rst_req_o}, 2);
    chk("R8 dma_en off", {31'd0, dma_en_o}, 0);

    // R9: DMA status
    @(negedge clk); dma_tx_done_i = 1'b1;
    @(negedge clk); dma_tx_done_i = 1'b0;
    rd(3'd5, v); chk("R9 tx", v, 32'h101);
    @(negedge clk); dma_rx_done_i = 1'b1;
    @(negedge clk); dma_rx_done_i = 1'b0;
    rd(3'd5, v); chk("R9 rx", v, 32'h103);
    @(negedge clk); dma_evt_i = 32'hF000_0C00;
    @(negedge clk); dma_evt_i = '0;
    rd(3'd5, v); chk("R9 upper set", v, 32'hF000_0D03);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R9 upper kept", v, 32'hF000_0C00);
    @(negedge clk); dma_evt_i = 32'h3FF;
    @(negedge clk); dma_evt_i = '0;
    for (int i = 0; i < 10; i++) begin
      wr(3'd5, 32'(1) << i);
      rd(3'd5, v);
      chk("R9 low clear sweep", v, 32'hF000_0C00 | (32'h3FF & ~((32'(2) << i) - 1)));
    end

    // R11: unmapped and hold
    rd(3'd6, v); chk("R11 addr6", v, 0);
    rd(3'd7, v); chk("R11 addr7", v, 0);
    rd(3'd0, v);
    @(negedge clk); reg_addr = 3'd5;
    @(negedge clk);
    chk("R11 hold", reg_rdata, 32'h300);

    // R10: empty indication when not ready
    fifo_ready_i = 1'b0;
    rd(3'd4, v); chk("R10 cstat empty", v, 32'h4);

    report();
  end
endmodule